// File: doc/BRIEF.md
# Flash Data-Phase Length Counter

This block decides when the data phase of a quad-SPI flash transfer ends. Software loads a 32-bit length value over a plain write port; a programmed value N asks for N+1 bytes. When the controller starts a transfer, the block raises busy, loads a down-counter and counts the per-byte completion strobes that the shift engine delivers. It flags the final byte and emits a one-cycle completion pulse when that byte finishes.

Three transfer modes are supported. In indirect mode the length is used as written. The all-ones value is an exception: it means "run to the top of flash". The top of flash comes from a flash-size field, where a capacity of 2^(S+1) bytes ends at byte address 2^(S+1)-1. The largest size setting makes such a transfer endless. In status-polling mode the length is clamped so that a poll never reads more than four bytes. In memory-mapped mode the length is not used and the counter stays idle. An abort input ends any transfer at once and produces no completion pulse.

Top module: `xfer_len_counter`

## Requirements
- R1: After reset, busy, last_byte and done_pulse are low and the stored length is zero, so a start in indirect mode with no prior write gives exactly one byte.
- R2: A write while busy is low stores wr_data. A later indirect start with stored value N (other than all ones) ends after exactly N+1 byte_done strobes.
- R3: A write while busy is high is ignored, and the next transfer uses the previously stored length.
- R4: While busy, last_byte is high exactly during the final byte of the transfer. A byte_done in that state drops busy and raises done_pulse for one cycle on the next clock edge.
- R5: In status-polling mode (mode = 2'b01) a stored length above 3 is treated as 3, so a poll ends after at most 4 bytes. This includes the all-ones value. Lengths 0 to 3 are used as stored.
- R6: In indirect mode (mode = 2'b00) a stored value of all ones ends the transfer on the byte whose address has its low S+1 bits all ones, where S is flash_size and S is below 31.
- R7: With an all-ones length in indirect mode and flash_size = 31, the transfer never ends by itself. busy stays high and done_pulse stays low until abort.
- R8: In memory-mapped mode (mode = 2'b10), and for the reserved code 2'b11, start is ignored and busy stays low.
- R9: abort drops busy on the next clock edge without a done_pulse.
- R10: A start while busy is high is ignored, and the running count is not reloaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the length value |
| wr_data | input | LEN_W | Length value to store (N gives N+1 bytes) |
| mode | input | 2 | 00 indirect, 01 status-polling, 10 memory-mapped, 11 reserved |
| flash_size | input | SIZE_W | Flash capacity exponent S, capacity 2^(S+1) bytes |
| start | input | 1 | Begin a data phase |
| abort | input | 1 | Stop the data phase at once |
| byte_addr | input | ADDR_W | Address of the byte currently being transferred |
| byte_done | input | 1 | One byte has finished on the serial side |
| busy | output | 1 | Data phase in progress |
| last_byte | output | 1 | Current byte is the final one |
| done_pulse | output | 1 | One-cycle pulse after the final byte |

## Verification
The bench builds the block with its default widths: a 32-bit length, a 5-bit flash-size field and a 32-bit byte address. These widths make the all-ones length and the endless size code 31 reachable exactly as the hardware sees them. Small flash-size codes such as 3 put the end-of-memory boundary within a few dozen strobes, whether the transfer starts at the base of the flash or partway up. Polling lengths above the clamp, including all ones, are driven through the same width.

// File: rtl/xlc_pkg.sv
package xlc_pkg;

    typedef enum logic [1:0] {
        XM_INDIRECT = 2'b00,
        XM_POLL     = 2'b01,
        XM_MAPPED   = 2'b10,
        XM_RSVD     = 2'b11
    } xfer_mode_e;

    localparam int POLL_MAX = 3;

    typedef struct packed {
        logic open_len;
        logic poll;
    } run_flags_t;

endpackage

// File: rtl/xlc_len_reg.sv
module xlc_len_reg #(
    parameter int LEN_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [LEN_W-1:0] wr_data,
    input  logic             busy,
    output logic [LEN_W-1:0] len_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q <= '0;
        end else if (wr_en && !busy) begin
            len_q <= wr_data;
        end
    end

    AST_WR_IGNORED_BUSY: assert property (@(posedge clk) disable iff (rst)
        (wr_en && busy) |=> $stable(len_q)); // R3

    AST_WR_TAKEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !busy) |=> (len_q == $past(wr_data))); // R2

endmodule

// File: rtl/xlc_end_detect.sv
module xlc_end_detect #(
    parameter int SIZE_W = 5,
    parameter int ADDR_W = 32
) (
    input  logic [SIZE_W-1:0] flash_size,
    input  logic [ADDR_W-1:0] byte_addr,
    output logic              at_end,
    output logic              endless
);

    logic [ADDR_W-1:0] top_mask;

    // Low S+1 address bits set for a capacity of 2^(S+1) bytes
    always_comb begin
        for (int i = 0; i < ADDR_W; i++) begin
            top_mask[i] = (int'(flash_size) >= i);
        end
    end

    assign endless = &flash_size;
    assign at_end  = !endless && ((byte_addr & top_mask) == top_mask);

    always_comb begin
        if (endless) begin
            AST_ENDLESS_NO_END: assert (!at_end); // R7
        end
    end

endmodule

// File: rtl/xlc_down_cnt.sv
module xlc_down_cnt
    import xlc_pkg::*;
#(
    parameter int LEN_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LEN_W-1:0] load_val,
    input  run_flags_t       flags_in,
    input  logic             byte_done,
    input  logic             abort,
    input  logic             at_end,
    output logic             busy,
    output logic             last_byte,
    output logic             done_pulse
);

    logic [LEN_W-1:0] cnt_q;
    logic             busy_q;
    logic             done_q;
    run_flags_t       flags_q;

    assign last_byte  = busy_q && (flags_q.open_len ? at_end : (cnt_q == '0));
    assign busy       = busy_q;
    assign done_pulse = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            flags_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (abort) begin
                cnt_q   <= '0;
                busy_q  <= 1'b0;
                flags_q <= '0;
            end else if (load) begin
                cnt_q   <= load_val;
                busy_q  <= 1'b1;
                flags_q <= flags_in;
            end else if (busy_q && byte_done) begin
                if (last_byte) begin
                    cnt_q   <= '0;
                    busy_q  <= 1'b0;
                    flags_q <= '0;
                    done_q  <= 1'b1;
                end else if (!flags_q.open_len) begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        done_q |-> !busy_q); // R4

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q); // R4

    AST_LAST_FINISHES: assert property (@(posedge clk) disable iff (rst)
        (last_byte && byte_done && !abort) |=> (done_q && !busy_q)); // R4

    AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (rst)
        abort |=> (!busy_q && !done_q)); // R9

    AST_POLL_BOUND: assert property (@(posedge clk) disable iff (rst)
        (busy_q && flags_q.poll) |-> (cnt_q <= LEN_W'(POLL_MAX))); // R5

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !abort && !(byte_done && last_byte)) |=> busy_q); // R10

endmodule

// File: rtl/xfer_len_counter.sv
module xfer_len_counter
    import xlc_pkg::*;
#(
    parameter int LEN_W  = 32,
    parameter int SIZE_W = 5,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [LEN_W-1:0]  wr_data,
    input  logic [1:0]        mode,
    input  logic [SIZE_W-1:0] flash_size,
    input  logic              start,
    input  logic              abort,
    input  logic [ADDR_W-1:0] byte_addr,
    input  logic              byte_done,
    output logic              busy,
    output logic              last_byte,
    output logic              done_pulse
);

    localparam logic [LEN_W-1:0] POLL_CAP = LEN_W'(POLL_MAX);

    xfer_mode_e       mode_e;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] load_val;
    logic             mode_live;
    logic             load;
    logic             at_end;
    logic             endless;
    run_flags_t       flags_in;

    assign mode_e    = xfer_mode_e'(mode);
    assign mode_live = (mode_e == XM_INDIRECT) || (mode_e == XM_POLL);
    assign load      = start && !busy && mode_live;

    always_comb begin
        flags_in.open_len = (mode_e == XM_INDIRECT) && (&len_q);
        flags_in.poll     = (mode_e == XM_POLL);
        if (flags_in.poll && (len_q > POLL_CAP)) begin
            load_val = POLL_CAP;
        end else begin
            load_val = len_q;
        end
    end

    xlc_len_reg #(.LEN_W(LEN_W)) u_len (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .busy    (busy),
        .len_q   (len_q)
    );

    xlc_end_detect #(.SIZE_W(SIZE_W), .ADDR_W(ADDR_W)) u_end (
        .flash_size (flash_size),
        .byte_addr  (byte_addr),
        .at_end     (at_end),
        .endless    (endless)
    );

    xlc_down_cnt #(.LEN_W(LEN_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .load_val   (load_val),
        .flags_in   (flags_in),
        .byte_done  (byte_done),
        .abort      (abort),
        .at_end     (at_end),
        .busy       (busy),
        .last_byte  (last_byte),
        .done_pulse (done_pulse)
    );

    AST_MAPPED_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!busy && !mode_live) |=> !busy); // R8

    AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && mode_live && !abort) |=> busy); // R2

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!busy && !done_pulse)); // R1

endmodule

// File: tb/xfer_len_counter_tb.sv
module xfer_len_counter_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 11;
    localparam int MAX_BYTES  = 300;

    typedef struct packed {
        logic [1:0]  mode;
        logic [31:0] len;
        logic [4:0]  size;
        logic [31:0] addr0;
        logic [31:0] expect_n;
    } vec_t;

    // mode: 0 indirect, 1 poll, 2 mapped, 3 reserved
    localparam vec_t VEC [NVEC] = '{
        '{2'd0, 32'd0,          5'd0,  32'h0,  32'd1},   // R2 len 0
        '{2'd0, 32'd1,          5'd0,  32'h0,  32'd2},   // R2 len 1
        '{2'd0, 32'd3,          5'd0,  32'h0,  32'd4},   // R2 len 3
        '{2'd0, 32'd9,          5'd2,  32'h0,  32'd10},  // R2 length wins over size
        '{2'd1, 32'd7,          5'd0,  32'h0,  32'd4},   // R5 clamp
        '{2'd1, 32'd2,          5'd0,  32'h0,  32'd3},   // R5 below clamp
        '{2'd1, 32'hFFFF_FFFF,  5'd3,  32'h0,  32'd4},   // R5 all ones in poll
        '{2'd0, 32'hFFFF_FFFF,  5'd3,  32'h0,  32'd16},  // R6 from base
        '{2'd0, 32'hFFFF_FFFF,  5'd3,  32'h1A, 32'd6},   // R6 partway
        '{2'd2, 32'd5,          5'd3,  32'h0,  32'd0},   // R8 mapped
        '{2'd3, 32'd5,          5'd3,  32'h0,  32'd0}    // R8 reserved
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [1:0]  mode = 2'd0;
    logic [4:0]  flash_size = '0;
    logic        start = 1'b0;
    logic        abort = 1'b0;
    logic [31:0] byte_addr = '0;
    logic        byte_done = 1'b0;
    logic        busy;
    logic        last_byte;
    logic        done_pulse;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xfer_len_counter u_dut (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .mode       (mode),
        .flash_size (flash_size),
        .start      (start),
        .abort      (abort),
        .byte_addr  (byte_addr),
        .byte_done  (byte_done),
        .busy       (busy),
        .last_byte  (last_byte),
        .done_pulse (done_pulse)
    );

    task automatic check(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Optional write, start, then strobe bytes until busy falls
    task automatic run_xfer(input string req, input bit do_wr, input logic [1:0] m,
                            input logic [31:0] len, input logic [4:0] sz,
                            input logic [31:0] a0, input int exp_n);
        int n = 0;
        int miss = 0;
        bit seen = 0;
        logic [31:0] a = a0;
        @(negedge clk);
        mode = m; flash_size = sz;
        if (do_wr) begin
            wr_en = 1'b1; wr_data = len;
            @(negedge clk);
            wr_en = 1'b0;
        end
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (busy && n < MAX_BYTES) begin
            byte_addr = a; byte_done = 1'b1;
            #1;
            if (last_byte != (n == exp_n - 1)) miss++;
            @(negedge clk);
            n++; a++;
            if (done_pulse) seen = 1;
        end
        byte_done = 1'b0;
        check({req, " byte count"}, n, exp_n);
        check({req, " R4 last_byte placement"}, miss, 0);
        if (exp_n > 0) check({req, " R4 done pulse"}, seen, 1);
        check({req, " R4 busy low after"}, busy, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 busy after reset", busy, 0);
        check("R1 last_byte after reset", last_byte, 0);
        check("R1 done_pulse after reset", done_pulse, 0);
        run_xfer("R1 reset length", 0, 2'd0, 32'd0, 5'd0, 32'h0, 1);

        for (int i = 0; i < NVEC; i++) begin
            run_xfer($sformatf("vec%0d", i), 1, VEC[i].mode, VEC[i].len,
                     VEC[i].size, VEC[i].addr0, int'(VEC[i].expect_n));
        end

        // R3: write while busy ignored
        @(negedge clk);
        mode = 2'd0; wr_en = 1'b1; wr_data = 32'd1;
        @(negedge clk);
        wr_en = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0; wr_en = 1'b1; wr_data = 32'd7;
        @(negedge clk);
        wr_en = 1'b0;
        check("R3 busy during write", busy, 1);
        byte_done = 1'b1;
        @(negedge clk);
        @(negedge clk);
        byte_done = 1'b0;
        check("R3 first transfer done", busy, 0);
        run_xfer("R3 rerun keeps old length", 0, 2'd0, 32'd0, 5'd0, 32'h0, 2);

        // R10: start while busy ignored
        @(negedge clk);
        wr_en = 1'b1; wr_data = 32'd2;
        @(negedge clk);
        wr_en = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0; byte_done = 1'b1;
        @(negedge clk);
        byte_done = 1'b0;
        run_xfer("R10 restart ignored", 0, 2'd0, 32'd0, 5'd0, 32'h0, 2);

        // R9: abort mid transfer
        @(negedge clk);
        wr_en = 1'b1; wr_data = 32'd9;
        @(negedge clk);
        wr_en = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0; byte_done = 1'b1;
        repeat (2) @(negedge clk);
        byte_done = 1'b0; abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        check("R9 busy after abort", busy, 0);
        check("R9 no done on abort", done_pulse, 0);
        @(negedge clk);
        check("R9 no late done", done_pulse, 0);

        // R7: endless with size 31
        begin
            bit seen = 0;
            @(negedge clk);
            flash_size = 5'd31; wr_en = 1'b1; wr_data = 32'hFFFF_FFFF;
            @(negedge clk);
            wr_en = 1'b0; start = 1'b1;
            @(negedge clk);
            start = 1'b0; byte_done = 1'b1;
            for (int k = 0; k < 100; k++) begin
                byte_addr = 32'hFFFF_FFD0 + 32'(k);
                @(negedge clk);
                if (done_pulse || !busy) seen = 1;
            end
            byte_done = 1'b0;
            check("R7 endless never ends", seen, 0);
            check("R7 still busy", busy, 1);
            abort = 1'b1;
            @(negedge clk);
            abort = 1'b0;
            check("R7 abort ends endless", busy, 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule